// File: doc/BRIEF.md
# Timer Compare Output Stage with Force Strobe

This block is the output end of an 8-bit timer that has two compare channels, A and B. On every cycle in which the counter advances, each channel compares the counter value against its own compare value. On a real match the channel sets its interrupt flag and, in non-PWM operation, acts on its output pin. The action is chosen by a 2-bit compare-output mode. When CTC operation is enabled and the matching channel is the one selected as TOP, the stage also asks the counter to clear. The counting logic and PWM duty shaping are outside this block.

Software reaches the block through one 8-bit control register. Its low four bits (one waveform-mode bit and a 3-bit clock select) are stored, read back and passed on to the counter logic. Its two top bits are write-only force strobes, one per channel. A force strobe applies the channel's current mode action to the pin one cycle later, exactly as a match would. It does not set the interrupt flag and does not clear the counter. Force strobes are ignored while the timer is in a PWM mode.

Top module: `tmr_cmp_out`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `pin_a`, `pin_b`, `flag_a`, `flag_b` and `cnt_clr` low and `ctl_rdata` equal to 0.
- R2: A write (`ctl_we`=1) stores `ctl_wdata[3:0]`. From the next cycle `ctl_rdata[3:0]` returns them, `wave_bit` equals bit 3 and `clk_sel` equals bits 2:0. `ctl_rdata[7:4]` always reads 0, including the force bits 7 and 6.
- R3: A real match is a cycle with `cnt_en`=1 and `cnt_val` equal to the channel's compare value. In the following cycle the channel flag is 1.
- R4: In non-PWM operation (`pwm_mode`=0), a real match changes the channel pin in the following cycle according to its mode. Mode 0 holds the pin, mode 1 toggles it, mode 2 drives it to 0 and mode 3 drives it to 1.
- R5: A control write with `pwm_mode`=0 and bit 7 set (channel A) or bit 6 set (channel B) applies that channel's mode action in the following cycle. It does not set the flag.
- R6: A force write while `pwm_mode`=1 has no effect on the pin or on the flag.
- R7: A force write never raises `cnt_clr`, even for the channel selected as CTC TOP.
- R8: When `ctc_en`=1, a real match on the channel picked by `ctc_sel` (0 = A, 1 = B) raises `cnt_clr` for exactly the following cycle. When `ctc_en`=0, `cnt_clr` stays low.
- R9: If a force and a real match hit the same channel in the same cycle, the mode action is applied once, and the flag is set by the match.
- R10: `flag_clr[0]` (channel A) and `flag_clr[1]` (channel B) clear the flag in the following cycle. A real match in the same cycle takes priority and leaves the flag set.
- R11: When `cnt_en`=0, equality between the counter and a compare value is not a match.
- R12: In PWM operation, real matches still set flags and CTC clear requests, but they leave both pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (7: force A, 6: force B, 3: wave bit, 2:0: clock select) |
| ctl_rdata | output | 8 | Control register read-back |
| wave_bit | output | 1 | Stored waveform-mode bit |
| clk_sel | output | 3 | Stored clock select |
| cnt_val | input | 8 | Current counter value |
| cnt_en | input | 1 | Counter advanced this cycle |
| pwm_mode | input | 1 | 1 = a PWM waveform mode is active |
| ctc_en | input | 1 | CTC operation enabled |
| ctc_sel | input | 1 | CTC TOP channel, 0 = A, 1 = B |
| cmp_a | input | 8 | Channel A compare value |
| cmp_b | input | 8 | Channel B compare value |
| mode_a | input | 2 | Channel A compare-output mode |
| mode_b | input | 2 | Channel B compare-output mode |
| flag_clr | input | 2 | Flag clear, bit 0 = A, bit 1 = B |
| pin_a | output | 1 | Channel A output pin |
| pin_b | output | 1 | Channel B output pin |
| flag_a | output | 1 | Channel A compare interrupt flag |
| flag_b | output | 1 | Channel B compare interrupt flag |
| cnt_clr | output | 1 | Counter clear request (CTC) |

## Verification
The bench targets the cycle where a force strobe coincides with a real match. A design that acts twice there would toggle the pin back to its old level. A design that lets the force path reach the flag or the clear request would show a flag or `cnt_clr` after a force-only write. The bench also drives matches together with flag clears, where a design with the wrong priority would lose the flag. It drives force writes and matches during PWM operation, where a design that forgets the mode gate would move the pin. Counter equality with `cnt_en` low is swept across all counter values, to catch a comparator that ignores the advance qualifier.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_FLIP = 2'b01,
    PIN_LOW  = 2'b10,
    PIN_HIGH = 2'b11
  } pin_act_e;

  localparam int CTL_W      = 8;
  localparam int FRC_A_BIT  = 7;
  localparam int FRC_B_BIT  = 6;
  localparam int CFG_W      = 4;

  function automatic logic pin_next(input pin_act_e act, input logic cur);
    case (act)
      PIN_FLIP: pin_next = ~cur;
      PIN_LOW:  pin_next = 1'b0;
      PIN_HIGH: pin_next = 1'b1;
      default:  pin_next = cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_cmp_ctl.sv
module tmr_cmp_ctl
  import tmr_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             pwm_mode,
  output logic [CTL_W-1:0] rdata,
  output logic [CFG_W-1:0] cfg,
  output logic [1:0]       frc
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata[CFG_W-1:0];
  end

  // force strobes are gated by the waveform mode and never stored
  assign frc[0] = we & wdata[FRC_A_BIT] & ~pwm_mode;
  assign frc[1] = we & wdata[FRC_B_BIT] & ~pwm_mode;
  assign cfg    = cfg_q;
  assign rdata  = {{(CTL_W-CFG_W){1'b0}}, cfg_q};

  always_comb begin
    AST_RSV_ZERO: assert (rdata[CTL_W-1:CFG_W] == '0); // R2
  end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_cmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       mode,
  input  logic             pwm_mode,
  input  logic             frc,
  input  logic             flag_clr,
  output logic             hit,
  output logic             pin,
  output logic             flag
);
  logic pin_q, flag_q, act;
  pin_act_e act_sel;

  assign hit     = cnt_en && (cnt_val == cmp_val);
  assign act_sel = pin_act_e'(mode);
  // one action per cycle whether it came from a match, a force, or both
  assign act     = (hit && !pwm_mode) || frc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (act) pin_q <= pin_next(act_sel, pin_q);
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  assign pin  = pin_q;
  assign flag = flag_q;

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(hit)); // R3
  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (rst)
    pwm_mode |=> $stable(pin_q)); // R12
  AST_KEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> $stable(pin_q)); // R4
  AST_FRC_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    (!hit && !flag_q) |=> !flag_q); // R5
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
  import tmr_cmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  output logic             wave_bit,
  output logic [2:0]       clk_sel,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_en,
  input  logic             pwm_mode,
  input  logic             ctc_en,
  input  logic             ctc_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic [1:0]       flag_clr,
  output logic             pin_a,
  output logic             pin_b,
  output logic             flag_a,
  output logic             flag_b,
  output logic             cnt_clr
);
  localparam int NCH = 2;

  logic [CFG_W-1:0] cfg;
  logic [NCH-1:0]   frc, hit, pin, flag;
  logic [CNT_W-1:0] cmp [NCH];
  logic [1:0]       mode [NCH];
  logic             clr_q;

  assign cmp[0]  = cmp_a;
  assign cmp[1]  = cmp_b;
  assign mode[0] = mode_a;
  assign mode[1] = mode_b;

  tmr_cmp_ctl u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .pwm_mode(pwm_mode), .rdata(ctl_rdata), .cfg(cfg), .frc(frc)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_en(cnt_en),
      .cmp_val(cmp[c]), .mode(mode[c]), .pwm_mode(pwm_mode),
      .frc(frc[c]), .flag_clr(flag_clr[c]),
      .hit(hit[c]), .pin(pin[c]), .flag(flag[c])
    );
  end

  // only a real match on the TOP channel may clear the counter
  always_ff @(posedge clk) begin
    if (rst) clr_q <= 1'b0;
    else     clr_q <= ctc_en && hit[ctc_sel];
  end

  assign wave_bit = cfg[3];
  assign clk_sel  = cfg[2:0];
  assign pin_a    = pin[0];
  assign pin_b    = pin[1];
  assign flag_a   = flag[0];
  assign flag_b   = flag[1];
  assign cnt_clr  = clr_q;

  AST_CLR_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> !clr_q); // R7
  AST_CLR_NEEDS_CTC: assert property (@(posedge clk) disable iff (rst)
    !ctc_en |=> !clr_q); // R8
endmodule

// File: tb/tmr_cmp_out_bench.sv
module tmr_cmp_out_bench;
  logic clk = 0;
  always #4 clk = ~clk;

  logic       rst = 1, ctl_we = 0, cnt_en = 0, pwm_mode = 0, ctc_en = 0, ctc_sel = 0;
  logic [7:0] ctl_wdata = 0, cnt_val = 0, cmp_a = 0, cmp_b = 0;
  logic [1:0] mode_a = 0, mode_b = 0, flag_clr = 0;
  logic [7:0] ctl_rdata;
  logic [2:0] clk_sel;
  logic       wave_bit, pin_a, pin_b, flag_a, flag_b, cnt_clr;

  tmr_cmp_out u_tmr_cmp_out (.*);

  int n_vec = 0, n_bad = 0;
  string tag = "R1";
  logic [3:0] e_cfg = 0;
  logic [1:0] e_pin = 0, e_flag = 0;
  logic       e_clr = 0;
  bit         done = 0;

  function automatic logic act_pin(input logic [1:0] m, input logic p);
    return (m == 2'd1) ? ~p : (m == 2'd2) ? 1'b0 : (m == 2'd3) ? 1'b1 : p;
  endfunction

  task automatic step();
    logic [1:0] h, f, m;
    logic [7:0] c;
    for (int k = 0; k < 2; k++) begin
      c = k ? cmp_b : cmp_a;
      m = k ? mode_b : mode_a;
      h[k] = cnt_en && (cnt_val == c);
      f[k] = ctl_we && ctl_wdata[7-k] && !pwm_mode;
    end
    if (rst) begin
      e_cfg = 0; e_pin = 0; e_flag = 0; e_clr = 0;
    end else begin
      e_clr = ctc_en && h[ctc_sel];
      for (int k = 0; k < 2; k++) begin
        m = k ? mode_b : mode_a;
        if ((h[k] && !pwm_mode) || f[k]) e_pin[k] = act_pin(m, e_pin[k]);
        if (h[k]) e_flag[k] = 1;
        else if (flag_clr[k]) e_flag[k] = 0;
      end
      if (ctl_we) e_cfg = ctl_wdata[3:0];
    end
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if ({pin_b, pin_a} !== e_pin || {flag_b, flag_a} !== e_flag || cnt_clr !== e_clr
        || ctl_rdata !== {4'b0, e_cfg} || {wave_bit, clk_sel} !== e_cfg) begin
      n_bad++;
      $display("FAIL %s: pin=%b flag=%b clr=%b rd=%h ws=%h  exp pin=%b flag=%b clr=%b rd=%h",
               tag, {pin_b, pin_a}, {flag_b, flag_a}, cnt_clr, ctl_rdata,
               {wave_bit, clk_sel}, e_pin, e_flag, e_clr, {4'b0, e_cfg});
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tag = "R1"; step(); step();
    rst = 0;

    // R2 and R6: every control byte, PWM active so force bits do nothing
    tag = "R2,R6"; pwm_mode = 1; mode_a = 2'd1; mode_b = 2'd1; ctl_we = 1;
    for (int v = 0; v < 256; v++) begin ctl_wdata = 8'(v); step(); end
    ctl_we = 0; step();

    // R3, R4, R8, R10, R11: all mode pairs, full counter sweep
    tag = "R3,R4,R8,R10,R11"; pwm_mode = 0; ctc_en = 1;
    for (int mp = 0; mp < 16; mp++) begin
      mode_a = 2'(mp); mode_b = 2'(mp >> 2);
      cmp_a = 8'(mp * 17 + 3); cmp_b = 8'(255 - mp * 13);
      ctc_sel = mp[0]; ctc_en = (mp != 5);
      for (int v = 0; v < 256; v++) begin
        cnt_val = 8'(v); cnt_en = (v % 3 != 1);
        flag_clr = 2'(v % 7 == 0 ? 3 : 0);
        step();
      end
    end
    cnt_en = 0; flag_clr = 2'b11; step(); flag_clr = 0;

    // R5, R7: force-only writes, TOP channel selected
    tag = "R5,R7"; ctc_en = 1;
    for (int mp = 0; mp < 16; mp++) begin
      mode_a = 2'(mp); mode_b = 2'(mp >> 2);
      for (int fb = 0; fb < 4; fb++) begin
        ctc_sel = fb[0]; ctl_we = 1; ctl_wdata = {2'(fb), 2'b00, 4'(mp)};
        step(); ctl_we = 0; step();
      end
    end

    // R9: force and match in the same cycle
    tag = "R9";
    for (int mp = 0; mp < 16; mp++) begin
      mode_a = 2'(mp); mode_b = 2'(mp >> 2);
      cnt_en = 1; cnt_val = 8'd40; cmp_a = 8'd40; cmp_b = 8'd40;
      ctl_we = 1; ctl_wdata = 8'hC0; step();
      ctl_we = 0; cnt_en = 0; flag_clr = 2'b11; step(); flag_clr = 0;
    end

    // R12 and R6: PWM mode with matches and forces
    tag = "R12,R6"; pwm_mode = 1; mode_a = 2'd1; mode_b = 2'd3;
    for (int v = 0; v < 64; v++) begin
      cnt_en = 1; cnt_val = 8'(v & 7); cmp_a = 8'd2; cmp_b = 8'd5;
      ctl_we = v[0]; ctl_wdata = 8'hC0;
      flag_clr = 2'(v[3] ? 3 : 0); ctc_sel = v[4];
      step();
    end
    ctl_we = 0;

    // R1 again: reset mid-run clears state
    tag = "R1"; rst = 1; step(); rst = 0; step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule